// File: doc/BRIEF.md
# Segmented Three-Operand Adder and Logic Unit

This block is the second arithmetic stage of a datapath. Each cycle it takes three operands X, Y and Z of `DATA_W` bits (48 by default) and a single carry-in. A 4-bit operation code selects one of four arithmetic forms, which add or subtract the operands in different combinations. The same code can instead select a bitwise logic function of X and Z. The result and the carry-outs are captured in an output register that has a synchronous reset and a clock enable.

An elaboration-time parameter `LANES` splits the datapath into one, two or four independent lanes of equal width. The choice is fixed by the design that instantiates the block and cannot change while it runs. Each lane computes on its own slice of the operands, and no carry crosses from one lane into the next. Each lane also reports its own carry-out. A typical use is a multiply-accumulate or a bank of narrow counters, where the value selected by the surrounding datapath is fed back as Z.

Top module: `tri_add_simd`

## Requirements
- R1: With op 4'b0000 the lane result is (Z + X + Y + CIN) modulo 2^n, where n = DATA_W/LANES is the lane width.
- R2: With op 4'b0001 the lane result is (~Z + X + Y + CIN) modulo 2^n, so with CIN = 1 it equals X + Y - Z.
- R3: With op 4'b0010 the lane result is the bitwise inverse of (Z + X + Y + CIN) modulo 2^n, which equals -Z - X - Y - CIN - 1.
- R4: With op 4'b0011 the lane result is (Z - (X + Y + CIN)) modulo 2^n.
- R5: Lane k occupies bits [k*n +: n] of every operand and of the result. No carry passes between lanes, and CIN enters every lane.
- R6: In an arithmetic op, a lane's carry-out is 1 exactly when the unsigned lane sum W + X + Y + CIN is at least 2^n, where W is Z for ops 0000 and 0010 and ~Z for ops 0001 and 0011. With two or four lanes, lane k drives carry_out[k]. With one lane, carry_out[3] carries it. Carry-out bits with no lane are 0.
- R7: Logic ops act on X and Z only: 0100 XOR, 0101 XNOR, 0110 AND, 0111 OR, 1000 NAND, 1001 NOR, 1010 X AND NOT Z, 1011 X OR NOT Z. In these ops carry_out is 0, and Y and CIN have no effect.
- R8: Ops 4'b1100 to 4'b1111 give a result of zero and a carry_out of zero.
- R9: The result and carry_out appear one clock edge after the inputs are presented with ce high. While ce is low, the result and carry_out hold their values.
- R10: When rst is high at a clock edge, the result and carry_out are cleared whatever the value of ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| ce | input | 1 | Clock enable of the output register |
| op | input | 4 | Operation code |
| cin | input | 1 | Carry-in, applied to every lane |
| x | input | DATA_W | Operand X |
| y | input | DATA_W | Operand Y |
| z | input | DATA_W | Operand Z |
| result | output | DATA_W | Registered result |
| carry_out | output | 4 | Registered per-lane carry-outs |

## Verification
Within a single cycle, a carry-out from one lane can coincide with the computation in the neighbouring lane, and the lane boundary must keep the two apart. To provoke this, X is made all ones in alternate lanes and a small Y or a full Z is added, so that a lane overflows next to a lane that does not. The same inputs go to instances built with one, two and four lanes. Each output is then compared with a per-lane model taken from the requirements: the bits of the neighbouring lane must come out as that lane's own sum, and every carry-out bit must land on its own index. A second collision is reset asserted in the same cycle as ce, which must leave zeros.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;

    localparam int COUT_W = 4;

    typedef enum logic [3:0] {
        OP_ADD     = 4'b0000,
        OP_NZ_ADD  = 4'b0001,
        OP_NEG_ALL = 4'b0010,
        OP_Z_SUB   = 4'b0011,
        OP_XOR     = 4'b0100,
        OP_XNOR    = 4'b0101,
        OP_AND     = 4'b0110,
        OP_OR      = 4'b0111,
        OP_NAND    = 4'b1000,
        OP_NOR     = 4'b1001,
        OP_ANDN    = 4'b1010,
        OP_ORN     = 4'b1011
    } op_e;

    typedef struct packed {
        logic arith;     // three-input adder path
        logic inv_z;     // use ~Z in the sum
        logic inv_out;   // invert the lane sum
        logic logic_op;  // bitwise path
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input logic [3:0] code);
        op_ctl_t c;
        c.arith    = (code[3:2] == 2'b00);
        c.inv_z    = c.arith && code[0];
        c.inv_out  = c.arith && code[1];
        c.logic_op = (code[3:2] == 2'b01) || (code[3:2] == 2'b10);
        return c;
    endfunction

    // carry-out index used by lane k for a given lane count
    function automatic int cout_index(input int lanes, input int k);
        return (lanes == 1) ? (COUT_W - 1) : k;
    endfunction

endpackage

// File: rtl/tri_add_lane.sv
module tri_add_lane #(
    parameter int W = 12
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic         cin,
    input  logic         inv_z,
    input  logic         inv_out,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int TW = W + 2;

    logic [W-1:0]  w_op;
    logic [W-1:0]  part_sum;
    logic [W-1:0]  part_carry;
    logic [TW-1:0] total;

    always_comb begin
        w_op       = inv_z ? ~z : z;
        // 3:2 compression ahead of a single carry-propagate add
        part_sum   = x ^ y ^ w_op;
        part_carry = (x & y) | (x & w_op) | (y & w_op);
        total      = TW'(part_sum) + (TW'(part_carry) << 1) + TW'(cin);
        sum        = inv_out ? ~total[W-1:0] : total[W-1:0];
        cout       = |total[TW-1:W];
    end
endmodule

// File: rtl/tri_logic_unit.sv
module tri_logic_unit
    import tri_add_pkg::*;
#(
    parameter int W = 48
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] z,
    output logic [W-1:0] out
);
    always_comb begin
        unique case (op)
            OP_XOR:  out = x ^ z;
            OP_XNOR: out = ~(x ^ z);
            OP_AND:  out = x & z;
            OP_OR:   out = x | z;
            OP_NAND: out = ~(x & z);
            OP_NOR:  out = ~(x | z);
            OP_ANDN: out = x & ~z;
            OP_ORN:  out = x | ~z;
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/tri_add_simd.sv
module tri_add_simd
    import tri_add_pkg::*;
#(
    parameter int DATA_W = 48,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [3:0]        op,
    input  logic              cin,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic [DATA_W-1:0] z,
    output logic [DATA_W-1:0] result,
    output logic [COUT_W-1:0] carry_out
);
    localparam int LANE_W = DATA_W / LANES;

    op_ctl_t           ctl;
    logic [DATA_W-1:0] arith_res;
    logic [COUT_W-1:0] arith_cout;
    logic [LANES-1:0]  lane_cout;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] next_res;
    logic [COUT_W-1:0] next_cout;
    logic [DATA_W-1:0] res_q;
    logic [COUT_W-1:0] cout_q;

    assign ctl = decode_op(op);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tri_add_lane #(.W(LANE_W)) u_lane (
            .x       (x[k*LANE_W +: LANE_W]),
            .y       (y[k*LANE_W +: LANE_W]),
            .z       (z[k*LANE_W +: LANE_W]),
            .cin     (cin),
            .inv_z   (ctl.inv_z),
            .inv_out (ctl.inv_out),
            .sum     (arith_res[k*LANE_W +: LANE_W]),
            .cout    (lane_cout[k])
        );
    end

    always_comb begin
        arith_cout = '0;
        for (int k = 0; k < LANES; k++) begin
            arith_cout[cout_index(LANES, k)] = lane_cout[k];
        end
    end

    tri_logic_unit #(.W(DATA_W)) u_logic (
        .op  (op),
        .x   (x),
        .z   (z),
        .out (logic_res)
    );

    always_comb begin
        if (ctl.arith) begin
            next_res  = arith_res;
            next_cout = arith_cout;
        end else if (ctl.logic_op) begin
            next_res  = logic_res;
            next_cout = '0;
        end else begin
            next_res  = '0;
            next_cout = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            cout_q <= '0;
        end else if (ce) begin
            res_q  <= next_res;
            cout_q <= next_cout;
        end
    end

    assign result    = res_q;
    assign carry_out = cout_q;

    // R1
    add_identity_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && op == 4'b0000 && x == '0 && y == '0 && !cin)
        |=> (result == $past(z) && carry_out == '0));

    // R7
    xor_self_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && op == 4'b0100 && x == z) |=> (result == '0 && carry_out == '0));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && op[3:2] == 2'b11) |=> (result == '0 && carry_out == '0));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(result) && $stable(carry_out)));

endmodule

// File: tb/tb_tri_add_simd.sv
module tb_tri_add_simd;
    localparam int DW = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce  = 1'b0;
    logic [3:0]    op  = '0;
    logic          cin = 1'b0;
    logic [DW-1:0] x = '0, y = '0, z = '0;
    logic [DW-1:0] r4, r2, r1;
    logic [3:0]    c4, c2, c1;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tri_add_simd #(.DATA_W(DW), .LANES(4)) dut (
        .clk(clk), .rst(rst), .ce(ce), .op(op), .cin(cin),
        .x(x), .y(y), .z(z), .result(r4), .carry_out(c4));
    tri_add_simd #(.DATA_W(DW), .LANES(2)) dut2 (
        .clk(clk), .rst(rst), .ce(ce), .op(op), .cin(cin),
        .x(x), .y(y), .z(z), .result(r2), .carry_out(c2));
    tri_add_simd #(.DATA_W(DW), .LANES(1)) dut1 (
        .clk(clk), .rst(rst), .ce(ce), .op(op), .cin(cin),
        .x(x), .y(y), .z(z), .result(r1), .carry_out(c1));

    // expected {carry_out, result} from the requirements
    function automatic logic [51:0] model(int lanes, logic [3:0] o,
        logic [47:0] a, logic [47:0] b, logic [47:0] c, logic ci);
        int n = 48 / lanes;
        logic [63:0] mask = (64'd1 << n) - 64'd1;
        logic [47:0] res = '0;
        logic [3:0]  co = '0;
        if (o[3:2] == 2'b00) begin
            for (int k = 0; k < lanes; k++) begin
                logic [63:0] xs = (64'(a) >> (k * n)) & mask;
                logic [63:0] ys = (64'(b) >> (k * n)) & mask;
                logic [63:0] zs = (64'(c) >> (k * n)) & mask;
                logic [63:0] ws = o[0] ? (~zs & mask) : zs;
                logic [63:0] s  = xs + ys + ws + 64'(ci);
                logic [63:0] rl = o[1] ? (~s & mask) : (s & mask);
                res = res | 48'(rl << (k * n));
                co[(lanes == 1) ? 3 : k] = (s >= (64'd1 << n));
            end
        end else begin
            case (o)
                4'b0100: res = a ^ c;
                4'b0101: res = ~(a ^ c);
                4'b0110: res = a & c;
                4'b0111: res = a | c;
                4'b1000: res = ~(a & c);
                4'b1001: res = ~(a | c);
                4'b1010: res = a & ~c;
                4'b1011: res = a | ~c;
                default: res = '0;
            endcase
        end
        return {co, res};
    endfunction

    task automatic check(string req, string who, logic [51:0] got, logic [51:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got cout=%h res=%h expected cout=%h res=%h",
                     req, who, got[51:48], got[47:0], exp[51:48], exp[47:0]);
        end
    endtask

    // present inputs with ce high, then check all three lane splits one edge later
    task automatic apply(string req, logic [3:0] o, logic [47:0] a,
                         logic [47:0] b, logic [47:0] c, logic ci);
        @(negedge clk);
        ce = 1'b1; op = o; x = a; y = b; z = c; cin = ci;
        @(negedge clk);
        check(req, "lanes4", {c4, r4}, model(4, o, a, b, c, ci));
        check(req, "lanes2", {c2, r2}, model(2, o, a, b, c, ci));
        check(req, "lanes1", {c1, r1}, model(1, o, a, b, c, ci));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10", "lanes4", {c4, r4}, '0);
        check("R10", "lanes1", {c1, r1}, '0);
    endtask

    task automatic t_add_forms;
        apply("R1", 4'b0000, 48'h0123_4567_89AB, 48'h0011_2233_4455, 48'h0F0F_0F0F_0F0F, 1'b1);
        apply("R2", 4'b0001, 48'h0000_0000_1000, 48'h0000_0000_0234, 48'h0000_0000_0100, 1'b1);
        apply("R2", 4'b0001, 48'h0005_0005_0005, 48'h0, 48'h0009_0009_0009, 1'b1);
        apply("R3", 4'b0010, 48'h1234_5678_9ABC, 48'h0000_1111_2222, 48'h0FED_CBA9_8765, 1'b0);
        apply("R3", 4'b0010, 48'h0, 48'h0, 48'h0, 1'b1);
        apply("R4", 4'b0011, 48'h0000_0000_0001, 48'h0000_0000_0001, 48'h0000_0000_0003, 1'b0);
        apply("R4", 4'b0011, 48'h0002_0002_0002, 48'h0, 48'h0001_0001_0001, 1'b1);
    endtask

    task automatic t_lane_boundary;
        apply("R5", 4'b0000, '1, 48'h1, 48'h0, 1'b0);
        apply("R5", 4'b0000, 48'h000F_FF00_0FFF, 48'h0, 48'h0000_0100_0001, 1'b0);
        apply("R5", 4'b0000, 48'h0, 48'h0, 48'h0, 1'b1);
        apply("R6", 4'b0000, '1, '1, '1, 1'b1);
        apply("R6", 4'b0001, '1, 48'h0, 48'h0, 1'b1);
        apply("R6", 4'b0011, 48'h0, 48'h0, 48'h0, 1'b0);
    endtask

    task automatic t_logic;
        logic [47:0] a = 48'hF0F0_CC33_A55A;
        logic [47:0] c = 48'h0FF0_3C3C_5A5A;
        for (int o = 4; o < 12; o++) begin
            apply("R7", 4'(o), a, 48'hDEAD_BEEF_1234, c, 1'b1);
            apply("R7", 4'(o), a, 48'h0, c, 1'b0);
        end
        apply("R7", 4'b0100, 48'h1357_9BDF_0246, 48'h1, 48'h1357_9BDF_0246, 1'b1);
    endtask

    task automatic t_reserved;
        for (int o = 12; o < 16; o++) begin
            apply("R8", 4'(o), '1, '1, '1, 1'b1);
        end
    endtask

    task automatic t_enable_hold;
        logic [51:0] e4, e1;
        apply("R9", 4'b0000, 48'h0000_0000_0010, 48'h0000_0000_0020, 48'h0000_0000_0030, 1'b0);
        e4 = model(4, 4'b0000, 48'h10, 48'h20, 48'h30, 1'b0);
        e1 = model(1, 4'b0000, 48'h10, 48'h20, 48'h30, 1'b0);
        @(negedge clk);
        ce = 1'b0; op = 4'b0000; x = '1; y = '1; z = '1; cin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9", "lanes4", {c4, r4}, e4);
        check("R9", "lanes1", {c1, r1}, e1);
    endtask

    task automatic t_reset_priority;
        apply("R10", 4'b0000, '1, '1, '1, 1'b1);
        @(negedge clk);
        rst = 1'b1; ce = 1'b1;
        @(negedge clk);
        check("R10", "lanes4", {c4, r4}, '0);
        check("R10", "lanes2", {c2, r2}, '0);
        rst = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_add_forms;
        t_lane_boundary;
        t_logic;
        t_reserved;
        t_enable_hold;
        t_reset_priority;
        finish_run;
    end

    initial begin
        #200us;
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: got no completion expected completion");
        finish_run;
    end
endmodule